// File: doc/BRIEF.md
# Lockable Slow-Clock Watchdog

This block is a supervision timer that counts down a 12-bit value on every rising edge of a slow clock. The slow clock is sampled and synchronized into the bus clock domain, where each of its rising edges becomes a one-cycle tick. Software restarts the count through a keyed control register. If the count runs out, the block raises a fault. The fault can drive an interrupt, a reset request, both, or neither.

All configuration sits in one 32-bit mode register, which accepts only its first write. That register holds the reload value, the disable bit, the two fault routing enables and two halt enables. The halt enables pause counting while the system is idle or while the processor is in debug. A write to the mode register whose fixed field does not hold all ones is reported as a configuration fault. Both kinds of fault are kept in a sticky status register that clears when it is read.

For a short window after each restart, the reload value is held constant. This window lasts a fixed number of slow ticks. A configuration change that lands inside the window cannot shorten the period that follows.

Top module: `oncecfg_wdog`

## Requirements
- R1: After reset the mode register (offset 0x04) reads 0x3FFFAFFF, the counter holds 0xFFF, the status flags are clear, and irq_o and wdrst_o are low.
- R2: Only the first write to offset 0x04 is stored. Later writes leave its read value unchanged.
- R3: Bits 11:0 of the mode register are the reload value. After a restart with reload value N, the fault is raised on the N-th counting tick, and the counter reloads from the same value at that point. The status register (offset 0x08) shows the counter in bits 27:16.
- R4: When bit 15 of the mode register is 1, the counter does not change on ticks.
- R5: wdrst_o is high while a fault flag is set and bit 13 of the mode register is 1. It stays low when bit 13 is 0.
- R6: irq_o is high while a fault flag is set and bit 12 of the mode register is 1. It stays low when bit 12 is 0.
- R7: When bit 29 is 1 and sys_idle is high, ticks do not decrement the counter. When bit 29 is 0, sys_idle has no effect.
- R8: When bit 28 is 1 and cpu_debug is high, ticks do not decrement the counter. When bit 28 is 0, cpu_debug has no effect.
- R9: A restart loads the counter from a reload copy. That copy does not follow the mode register for 3 slow ticks after the restart.
- R10: Each rising edge of slow_clk decrements the counter exactly once, no matter how long slow_clk stays high.
- R11: A restart happens only on a write to offset 0x00 with 0xA5 in bits 31:24 and bit 0 set. Any other write there leaves the counter unchanged.
- R12: An accepted mode write whose bits 27:16 differ from 0xFFF sets the error flag, which is bit 1 of the status register.
- R13: The underflow flag (status bit 0) and the error flag are sticky. A read of offset 0x08 returns them and clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Slow clock, sampled as data |
| bus_addr | input | 4 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a read of status clears its flags |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sys_idle | input | 1 | System idle indication |
| cpu_debug | input | 1 | Processor debug indication |
| irq_o | output | 1 | Fault interrupt |
| wdrst_o | output | 1 | Fault reset request |

## Verification
The bench sweeps all sixteen combinations of the two halt enables and the two halt inputs. A design with a swapped or unmasked halt gate would count where it must freeze, or freeze where it must count. It also sweeps the four combinations of the fault routing enables and checks each output against its own enable, which catches swapped routing bits. It issues a second restart inside the hold window right after the first mode write. A design without the hold would reload the new value at once instead of the old one. Further checks cover rejected restart keys, a second mode write, a slow clock held high for many cycles (which must give one tick only), and the clearing of the flags on a status read.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam logic [7:0]  ADDR_CTL  = 8'h00;
  localparam logic [7:0]  ADDR_MODE = 8'h04;
  localparam logic [7:0]  ADDR_STAT = 8'h08;
  localparam logic [7:0]  RST_KEY   = 8'hA5;
  localparam logic [DATA_W-1:0] MODE_RESET = 32'h3FFF_AFFF;
  // mode register bit positions
  localparam int unsigned MB_IDLE_HALT = 29;
  localparam int unsigned MB_DBG_HALT  = 28;
  localparam int unsigned MB_ONES_LSB  = 16;
  localparam int unsigned MB_ONES_W    = 12;
  localparam int unsigned MB_DISABLE   = 15;
  localparam int unsigned MB_RST_EN    = 13;
  localparam int unsigned MB_IRQ_EN    = 12;
  localparam int unsigned ST_CNT_LSB   = 16;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_clk,
  output logic tick
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], slow_clk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign tick = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/wdog_modereg.sv
module wdog_modereg
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mode_q,
  output logic              locked,
  output logic              err_set
);
  logic [DATA_W-1:0] mode_d;
  logic              lock_d;

  always_comb begin
    mode_d  = mode_q;
    lock_d  = locked;
    err_set = 1'b0;
    if (wr && !locked) begin
      mode_d  = wdata;
      lock_d  = 1'b1;
      err_set = wdata[MB_ONES_LSB +: MB_ONES_W] != {MB_ONES_W{1'b1}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      locked <= 1'b0;
    end else begin
      mode_q <= mode_d;
      locked <= lock_d;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned GUARD_TICKS = 3,
  parameter logic [CNT_W-1:0] CNT_RESET = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             halt,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             udf_set
);
  localparam int unsigned GW = $clog2(GUARD_TICKS + 1);

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] shadow_d;
  logic [GW-1:0]    guard_q;
  logic [GW-1:0]    guard_d;
  logic             run;

  assign run = tick & enable & ~halt;

  always_comb begin
    shadow_d = (guard_q == '0) ? reload : shadow_q;
    guard_d  = guard_q;
    if (tick && guard_q != '0) guard_d = guard_q - 1'b1;
    if (restart) guard_d = GW'(GUARD_TICKS);
  end

  always_comb begin
    cnt_d   = cnt_q;
    udf_set = 1'b0;
    if (restart) begin
      cnt_d = shadow_q;
    end else if (run) begin
      if (cnt_q <= CNT_W'(1)) begin
        udf_set = 1'b1;
        cnt_d   = shadow_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= CNT_RESET;
      shadow_q <= CNT_RESET;
      guard_q  <= '0;
    end else begin
      cnt_q    <= cnt_d;
      shadow_q <= shadow_d;
      guard_q  <= guard_d;
    end
  end
endmodule

// File: rtl/oncecfg_wdog.sv
module oncecfg_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned GUARD_TICKS = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sys_idle,
  input  logic              cpu_debug,
  output logic              irq_o,
  output logic              wdrst_o
);
  logic              rst_s_n;
  logic              tick;
  logic [DATA_W-1:0] mode_q;
  logic              locked;
  logic              err_set;
  logic              udf_set;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_ctl, wr_mode, rd_stat, restart, halt;
  logic              udf_q, udf_d, err_q, err_d, fault;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s_n));

  wdog_tick_sync #(.STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_s_n), .slow_clk(slow_clk), .tick(tick));

  assign wr_ctl  = bus_we && (bus_addr == ADDR_W'(ADDR_CTL));
  assign wr_mode = bus_we && (bus_addr == ADDR_W'(ADDR_MODE));
  assign rd_stat = bus_re && (bus_addr == ADDR_W'(ADDR_STAT));
  assign restart = wr_ctl && (bus_wdata[31:24] == RST_KEY) && bus_wdata[0];
  assign halt    = (mode_q[MB_IDLE_HALT] & sys_idle) |
                   (mode_q[MB_DBG_HALT]  & cpu_debug);

  wdog_modereg u_mode (
    .clk(clk), .rst_n(rst_s_n), .wr(wr_mode), .wdata(bus_wdata),
    .mode_q(mode_q), .locked(locked), .err_set(err_set));

  wdog_counter #(.CNT_W(CNT_W), .GUARD_TICKS(GUARD_TICKS),
                 .CNT_RESET(MODE_RESET[CNT_W-1:0])) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .tick(tick),
    .enable(~mode_q[MB_DISABLE]), .halt(halt), .restart(restart),
    .reload(mode_q[CNT_W-1:0]), .cnt_q(cnt_q), .udf_set(udf_set));

  // sticky fault flags: a new fault wins over a clearing read
  always_comb begin
    udf_d = rd_stat ? 1'b0 : udf_q;
    err_d = rd_stat ? 1'b0 : err_q;
    if (udf_set) udf_d = 1'b1;
    if (err_set) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      udf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      udf_q <= udf_d;
      err_q <= err_d;
    end
  end

  assign fault   = udf_q | err_q;
  assign irq_o   = fault & mode_q[MB_IRQ_EN];
  assign wdrst_o = fault & mode_q[MB_RST_EN];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADDR_MODE)) begin
      bus_rdata = mode_q;
    end else if (bus_addr == ADDR_W'(ADDR_STAT)) begin
      bus_rdata[ST_CNT_LSB +: CNT_W] = cnt_q;
      bus_rdata[1] = err_q;
      bus_rdata[0] = udf_q;
    end
  end
endmodule

// File: rtl/oncecfg_wdog_chk.sv
module oncecfg_wdog_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] mode_q,
  input logic          locked,
  input logic          irq_o,
  input logic          wdrst_o
);
  p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(mode_q)));
  p_rst_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdrst_o |-> mode_q[13]);
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> mode_q[12]);
endmodule

module wdog_cnt_chk #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned GUARD_TICKS = 3
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  tick,
  input logic                                  enable,
  input logic                                  halt,
  input logic                                  restart,
  input logic [CNT_W-1:0]                      cnt_q,
  input logic [CNT_W-1:0]                      shadow_q,
  input logic [$clog2(GUARD_TICKS + 1)-1:0]    guard_q
);
  p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !restart) |=> $stable(cnt_q));
  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !restart) |=> $stable(cnt_q));
  p_guard_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_q != '0) |=> $stable(shadow_q));
  p_tick_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

bind oncecfg_wdog oncecfg_wdog_chk #(.DW(32)) u_top_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .locked(locked),
  .irq_o(irq_o), .wdrst_o(wdrst_o));

bind wdog_counter wdog_cnt_chk #(.CNT_W(CNT_W), .GUARD_TICKS(GUARD_TICKS)) u_cnt_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .halt(halt),
  .restart(restart), .cnt_q(cnt_q), .shadow_q(shadow_q), .guard_q(guard_q));

// File: tb/oncecfg_wdog_bench.sv
`timescale 1ns/1ps
module oncecfg_wdog_bench;
  logic        clk;
  logic        rst_n;
  logic        slow_clk;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic        bus_re;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        sys_idle;
  logic        cpu_debug;
  logic        irq_o;
  logic        wdrst_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  oncecfg_wdog u_oncecfg_wdog (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sys_idle(sys_idle), .cpu_debug(cpu_debug),
    .irq_o(irq_o), .wdrst_o(wdrst_o));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; slow_clk = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_re = 1'b0;
    bus_wdata = '0; sys_idle = 1'b0; cpu_debug = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic stick(input int high_cycles);
    @(negedge clk);
    slow_clk = 1'b1;
    repeat (high_cycles) @(negedge clk);
    slow_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic get_cnt(output logic [31:0] c);
    logic [31:0] s;
    rd(4'h8, s);
    c = (s >> 16) & 32'hFFF;
  endtask

  task automatic restart();
    wr(4'h0, 32'hA500_0001);
  endtask

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state
    rd(4'h4, v);        chk("R1 mode reset", v, 32'h3FFF_AFFF);
    rd(4'h8, v);        chk("R1 status reset", v, 32'h0FFF_0000);
    chk("R1 irq low", {31'b0, irq_o}, 0);
    chk("R1 rst low", {31'b0, wdrst_o}, 0);
    // R4 disabled by default
    restart();
    stick(4); stick(4); stick(4);
    get_cnt(v);         chk("R4 disabled holds", v, 32'hFFF);
    // R2 write once
    wr(4'h4, 32'h0FFF_1007);
    rd(4'h4, v);        chk("R2 first write", v, 32'h0FFF_1007);
    wr(4'h4, 32'h3FFF_B001);
    rd(4'h4, v);        chk("R2 second ignored", v, 32'h0FFF_1007);
    // R3 period, R11 key
    restart();
    get_cnt(v);         chk("R3 loaded", v, 7);
    stick(4); stick(4);
    get_cnt(v);         chk("R3 two ticks", v, 5);
    wr(4'h0, 32'h5A00_0001);
    get_cnt(v);         chk("R11 bad key", v, 5);
    wr(4'h0, 32'hA500_0000);
    get_cnt(v);         chk("R11 bit0 clear", v, 5);
    restart();
    get_cnt(v);         chk("R11 good key", v, 7);
    for (int i = 0; i < 6; i++) stick(4);
    chk("R3 no fault before N", {31'b0, irq_o}, 0);
    stick(4);
    chk("R6 irq on fault", {31'b0, irq_o}, 1);
    chk("R5 rst masked", {31'b0, wdrst_o}, 0);
    rd(4'h8, v);        chk("R13 status set", v, 32'h0007_0001);
    rd(4'h8, v);        chk("R13 cleared on read", v, 32'h0007_0000);
    chk("R13 irq cleared", {31'b0, irq_o}, 0);
    // R10 long-high slow clock gives one tick
    stick(30);
    get_cnt(v);         chk("R10 single tick", v, 6);

    // R5/R6 routing sweep
    for (int m = 0; m < 4; m++) begin
      do_reset();
      wr(4'h4, 32'h0FFF_0002 | (32'(m & 1) << 12) | (32'(m >> 1) << 13));
      restart();
      stick(4); stick(4);
      chk("R6 irq routing", {31'b0, irq_o}, 32'(m & 1));
      chk("R5 rst routing", {31'b0, wdrst_o}, 32'(m >> 1));
      rd(4'h8, v);      chk("R3 underflow flag", v & 32'h3, 1);
    end

    // R7/R8 halt sweep
    for (int m = 0; m < 16; m++) begin
      logic ih, dh, id, db;
      ih = m[0]; dh = m[1]; id = m[2]; db = m[3];
      do_reset();
      wr(4'h4, 32'h0FFF_000A | (32'(ih) << 29) | (32'(dh) << 28));
      restart();
      sys_idle = id; cpu_debug = db;
      stick(4);
      sys_idle = 1'b0; cpu_debug = 1'b0;
      get_cnt(v);
      chk("R7 R8 halt gating", v, ((ih && id) || (dh && db)) ? 10 : 9);
    end

    // R12 error fault
    do_reset();
    wr(4'h4, 32'h00FF_1005);
    chk("R12 irq on error", {31'b0, irq_o}, 1);
    rd(4'h8, v);        chk("R12 error flag", v & 32'h3, 2);

    // R9 hold window
    do_reset();
    restart();
    wr(4'h4, 32'h0FFF_0003);
    restart();
    get_cnt(v);         chk("R9 old reload in window", v, 32'hFFF);
    stick(4); stick(4); stick(4);
    get_cnt(v);         chk("R9 counting", v, 32'hFFC);
    restart();
    get_cnt(v);         chk("R9 new reload after window", v, 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule